// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 16-bit processor built around one accumulator. Words are 16 bits wide and addresses are 12 bits wide. The core has a program counter, an address register, a data staging register, an instruction register, an 8-bit output latch, a signed-overflow flag and a run flag. A phase sequencer steps each instruction through two fetch cycles and one decode cycle. It then runs one to three execute cycles, and each register-transfer step takes exactly one clock.

The 4096-word memory sits inside the core and has one port. While reset is held, or after the core has halted, that port belongs to a loader interface. A host uses it to place a program and its data into memory. Once reset is released, the core starts at address 0. It runs until it reaches a halt instruction. The host then reads the results back through the same interface.

The opcode is in instruction bits [15:12] and the operand address is in bits [11:0]. The core supports direct and indirect memory operations, a subroutine call, jumps, a three-way conditional skip and byte-wide input and output.

Top module: `acc_core`

## Requirements
- R1: Every instruction takes two fetch cycles and one decode cycle. The execute cycles then depend on the opcode: 3 for opcodes 0x0, 0xB, 0xD and 0xE; 2 for 0x1 to 0x4; 1 for all others. A program made of Load then Halt drops `running` at the 9th clock after reset is released. Clear then Halt takes 8 clocks.
- R2: While reset is held, `acc`, `pc`, `out_data` and `ovf` read zero and `running` reads one. Execution begins at address 0.
- R3: Load (0x1) copies memory at the operand address into the accumulator. Store (0x2) writes the accumulator to that address. Clear (0xA) zeroes the accumulator.
- R4: Add (0x3) and subtract (0x4) combine the accumulator with the memory operand modulo 2^16. They set `ovf` to the signed two's-complement overflow of that operation. Every other opcode leaves `ovf` unchanged, except indirect add.
- R5: Subroutine call (0x0) with operand X stores {4'b0, return address} at X. It then continues execution at X+1.
- R6: Conditional skip (0x8) uses bits [11:10] to pick a test: 00 is accumulator negative, 01 is zero, 10 is positive (nonzero with the sign bit clear). Code 11 never skips. When the test holds, the next instruction is skipped.
- R7: Jump (0x9) continues at the operand address. Indirect jump (0xC) continues at bits [11:0] of the memory word found at the operand address.
- R8: Indirect add, load and store (0xB, 0xD, 0xE) treat bits [11:0] of the word at the operand as the real address. Indirect add updates `ovf` in the same way as add.
- R9: Input (0x5) writes `in_data` into accumulator bits [7:0] and keeps bits [15:8]. Output (0x6) copies accumulator bits [7:0] to `out_data`.
- R10: Halt (0x7) drops `running`. After that, `pc`, `acc` and `out_data` hold their values until the next reset.
- R11: Opcode 0xF does nothing, whatever its low bits are, and execution continues with the next word.
- R12: While reset is held or the core is halted, `prog_we` writes `prog_wdata` to `prog_addr`. During that time `prog_rdata` shows the word at `prog_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Loader write strobe (idle core only) |
| prog_addr | input | 12 | Loader word address |
| prog_wdata | input | 16 | Loader write data |
| prog_rdata | output | 16 | Word at `prog_addr` (idle core only) |
| in_data | input | 8 | Byte taken by the input instruction |
| out_data | output | 8 | Output latch |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| ovf | output | 1 | Signed overflow flag |
| running | output | 1 | Run flag; low once halted |

## Verification
Subroutine call makes two transfers in one cycle: the memory write of the staged return address, and the increment of the address register. The write must use the address from before the increment. The bench calls a subroutine whose body returns through an indirect jump on the saved slot. It then checks that the saved word is the exact return address and that the program halts at that return point. Cycle counts up to halt show whether either transfer moved to another cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int IO_W   = 8;
    localparam int OP_W   = 4;

    typedef enum logic [3:0] {
        OP_CALL   = 4'h0,
        OP_LOAD   = 4'h1,
        OP_STORE  = 4'h2,
        OP_ADD    = 4'h3,
        OP_SUB    = 4'h4,
        OP_IN     = 4'h5,
        OP_OUT    = 4'h6,
        OP_HALT   = 4'h7,
        OP_SKIP   = 4'h8,
        OP_JUMP   = 4'h9,
        OP_CLEAR  = 4'hA,
        OP_ADDI   = 4'hB,
        OP_JUMPI  = 4'hC,
        OP_LOADI  = 4'hD,
        OP_STOREI = 4'hE,
        OP_NOP    = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        PH_F1, PH_F2, PH_DEC, PH_EX1, PH_EX2, PH_EX3, PH_HALT
    } phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
    } alu_res_t;

    // Number of execute cycles for each opcode.
    function automatic logic [1:0] exec_len(opcode_e op);
        case (op)
            OP_CALL, OP_ADDI, OP_LOADI, OP_STOREI: return 2'd3;
            OP_LOAD, OP_STORE, OP_ADD, OP_SUB:     return 2'd2;
            default:                               return 2'd1;
        endcase
    endfunction

    // Skip test selected by a two-bit code.
    function automatic logic skip_hit(logic [1:0] code, logic [DATA_W-1:0] a);
        case (code)
            2'b00:   return a[DATA_W-1];
            2'b01:   return a == '0;
            2'b10:   return !a[DATA_W-1] && (a != '0);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DW = acc_pkg::DATA_W,
    parameter int AW = acc_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[addr] <= wdata;
    end

    assign rdata = store_q[addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = acc_pkg::DATA_W
) (
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic              sub,
    output acc_pkg::alu_res_t res
);
    logic [DW-1:0] b_eff;
    logic [DW-1:0] sum;

    always_comb begin
        b_eff     = sub ? ~b : b;
        sum       = a + b_eff + {{(DW-1){1'b0}}, sub};
        res.value = sum;
        res.ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    output phase_e  phase
);
    phase_e     nxt;
    logic [1:0] len;

    always_comb begin
        len = exec_len(op);
        nxt = phase;
        case (phase)
            PH_F1:   nxt = PH_F2;
            PH_F2:   nxt = PH_DEC;
            PH_DEC:  nxt = PH_EX1;
            PH_EX1:  nxt = (len == 2'd1) ? ((op == OP_HALT) ? PH_HALT : PH_F1) : PH_EX2;
            PH_EX2:  nxt = (len == 2'd2) ? PH_F1 : PH_EX3;
            PH_EX3:  nxt = PH_F1;
            default: nxt = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_F1;
        else     phase <= nxt;
    end

    AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        phase == PH_DEC |=> phase == PH_EX1); // R1
    AST_HALT_ABSORBS: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HALT |=> phase == PH_HALT); // R10
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DW = acc_pkg::DATA_W,
    parameter int AW = acc_pkg::ADDR_W,
    parameter int IW = acc_pkg::IO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_wdata,
    output logic [DW-1:0] prog_rdata,
    input  logic [IW-1:0] in_data,
    output logic [IW-1:0] out_data,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          ovf,
    output logic          running
);
    localparam int OPW = acc_pkg::OP_W;

    logic [DW-1:0] ac_q, mbr_q, ir_q;
    logic [AW-1:0] pc_q, mar_q;
    logic [IW-1:0] out_q;
    logic          ovf_q, run_q;

    phase_e   ph;
    opcode_e  op;
    alu_res_t alu;

    logic          idle, core_we;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rdata;

    assign op = opcode_e'(ir_q[DW-1 -: OPW]);

    acc_seq u_seq (.clk(clk), .rst(rst), .op(op), .phase(ph));

    acc_alu #(.DW(DW)) u_alu (.a(ac_q), .b(mbr_q), .sub(op == OP_SUB), .res(alu));

    assign idle    = rst || !run_q;
    assign core_we = (ph == PH_EX2 && (op == OP_CALL || op == OP_STORE))
                  || (ph == PH_EX3 && op == OP_STOREI);
    assign m_addr  = idle ? prog_addr  : mar_q;
    assign m_wdata = idle ? prog_wdata : mbr_q;

    acc_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .we(idle ? prog_we : core_we),
        .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0; mbr_q <= '0; ir_q <= '0;
            pc_q <= '0; mar_q <= '0; out_q <= '0;
            ovf_q <= 1'b0; run_q <= 1'b1;
        end else begin
            case (ph)
                PH_F1:  mar_q <= pc_q;
                PH_F2:  begin ir_q <= m_rdata; pc_q <= pc_q + 1'b1; end
                PH_DEC: mar_q <= ir_q[AW-1:0];
                PH_EX1: begin
                    case (op)
                        OP_CALL:                      mbr_q <= {{(DW-AW){1'b0}}, pc_q};
                        OP_LOAD, OP_ADD, OP_SUB:      mbr_q <= m_rdata;
                        OP_STORE:                     mbr_q <= ac_q;
                        OP_IN:                        ac_q[IW-1:0] <= in_data;
                        OP_OUT:                       out_q <= ac_q[IW-1:0];
                        OP_HALT:                      run_q <= 1'b0;
                        OP_SKIP: if (skip_hit(ir_q[AW-1 -: 2], ac_q)) pc_q <= pc_q + 1'b1;
                        OP_JUMP:                      pc_q <= ir_q[AW-1:0];
                        OP_CLEAR:                     ac_q <= '0;
                        OP_ADDI, OP_LOADI, OP_STOREI: mar_q <= m_rdata[AW-1:0];
                        OP_JUMPI:                     pc_q <= m_rdata[AW-1:0];
                        default: ;
                    endcase
                end
                PH_EX2: begin
                    case (op)
                        OP_CALL:           mar_q <= mar_q + 1'b1;
                        OP_LOAD:           ac_q <= mbr_q;
                        OP_ADD, OP_SUB:    begin ac_q <= alu.value; ovf_q <= alu.ovf; end
                        OP_ADDI, OP_LOADI: mbr_q <= m_rdata;
                        OP_STOREI:         mbr_q <= ac_q;
                        default: ;
                    endcase
                end
                PH_EX3: begin
                    case (op)
                        OP_CALL:  pc_q <= mar_q;
                        OP_ADDI:  begin ac_q <= alu.value; ovf_q <= alu.ovf; end
                        OP_LOADI: ac_q <= mbr_q;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign acc        = ac_q;
    assign pc         = pc_q;
    assign out_data   = out_q;
    assign ovf        = ovf_q;
    assign running    = run_q;
    assign prog_rdata = m_rdata;

    AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (rst)
        ph == PH_F2 |=> pc_q == $past(pc_q) + 1'b1); // R1
    AST_DECODE_LOADS_MAR: assert property (@(posedge clk) disable iff (rst)
        ph == PH_DEC |=> mar_q == $past(ir_q[AW-1:0])); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ph inside {PH_F1, PH_F2, PH_DEC, PH_EX1, PH_HALT}) |=> $stable(ovf_q)); // R4
    AST_INPUT_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EX1 && op == OP_IN) |=> ac_q[DW-1:IW] == $past(ac_q[DW-1:IW])); // R9
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (!run_q && $stable(pc_q) && $stable(ac_q) && $stable(out_q))); // R10
    AST_HALT_PHASE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HALT) == !run_q); // R10
    AST_CALL_RETURNS_PAST_SLOT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EX3 && op == OP_CALL) |=> pc_q == $past(mar_q)); // R5
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [11:0] prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic [15:0] prog_rdata;
    logic [7:0]  in_data = '0;
    logic [7:0]  out_data;
    logic [15:0] acc;
    logic [11:0] pc;
    logic        ovf, running;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    acc_core i_acc_core (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .prog_rdata(prog_rdata), .in_data(in_data),
        .out_data(out_data), .acc(acc), .pc(pc), .ovf(ovf), .running(running)
    );

    function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] x);
        return {op, x};
    endfunction

    function automatic logic [15:0] exp_val(logic [15:0] a, logic [15:0] b, bit sub);
        return sub ? a - b : a + b;
    endfunction

    function automatic bit exp_ovf(logic [15:0] a, logic [15:0] b, bit sub);
        logic [15:0] r = sub ? a - b : a + b;
        if (sub) return (a[15] != b[15]) && (r[15] != a[15]);
        return (a[15] == b[15]) && (r[15] != a[15]);
    endfunction

    function automatic bit exp_skip(logic [1:0] c, logic [15:0] v);
        case (c)
            2'b00:   return v[15];
            2'b01:   return v == 16'h0;
            2'b10:   return !v[15] && v != 16'h0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(logic [11:0] a, logic [15:0] d);
        prog_addr = a; prog_wdata = d; prog_we = 1'b1;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic peek(logic [11:0] a, output logic [15:0] d);
        prog_addr = a;
        #1;
        d = prog_rdata;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        rst = 1'b0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (!running) break;
            if (cyc > 4000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog: run did not halt, got running=1 expected 0");
                break;
            end
        end
    endtask

    initial begin
        int cyc;
        logic [15:0] w;
        void'($urandom(32'h1357));

        // R2: reset state
        hold_reset();
        chk("R2 acc", acc, 0); chk("R2 pc", pc, 0);
        chk("R2 out", out_data, 0); chk("R2 ovf", ovf, 0);
        chk("R2 running", running, 1);

        // R1 timing: Load; Halt
        put(12'h000, ins(4'h1, 12'h020)); put(12'h001, ins(4'h7, 0));
        put(12'h020, 16'hBEEF);
        run(cyc);
        chk("R1 load-halt cycles", cyc, 9);
        chk("R3 load acc", acc, 16'hBEEF);
        chk("R10 halt pc", pc, 2);
        repeat (8) @(negedge clk);
        chk("R10 pc frozen", pc, 2); chk("R10 acc frozen", acc, 16'hBEEF);
        chk("R10 running low", running, 0);
        // R12: loader works while halted
        put(12'h123, 16'h5A5A);
        peek(12'h123, w); chk("R12 write while halted", w, 16'h5A5A);

        // R1 timing: Clear; Halt
        hold_reset();
        put(12'h000, ins(4'hA, 0)); put(12'h001, ins(4'h7, 0));
        run(cyc);
        chk("R1 clear-halt cycles", cyc, 8);
        chk("R3 clear acc", acc, 0);

        // R3 R4 random and corner add/sub
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a, b;
            bit sub;
            logic [31:0] r1 = $urandom();
            logic [31:0] r2 = $urandom();
            a = r1[15:0]; b = r2[15:0]; sub = r1[16];
            case (i)
                0: begin a = 16'h7FFF; b = 16'h0001; sub = 0; end
                1: begin a = 16'h8000; b = 16'h0001; sub = 1; end
                2: begin a = 16'hFFFF; b = 16'h0001; sub = 0; end
                3: begin a = 16'h0000; b = 16'h8000; sub = 1; end
                default: ;
            endcase
            hold_reset();
            put(12'h000, ins(4'h1, 12'h030));
            put(12'h001, ins(sub ? 4'h4 : 4'h3, 12'h031));
            put(12'h002, ins(4'h2, 12'h032));
            put(12'h003, ins(4'h6, 0));
            put(12'h004, ins(4'h7, 0));
            put(12'h030, a); put(12'h031, b); put(12'h032, 16'h0);
            run(cyc);
            chk("R4 acc", acc, exp_val(a, b, sub));
            chk("R4 ovf", ovf, exp_ovf(a, b, sub));
            peek(12'h032, w); chk("R3 store", w, exp_val(a, b, sub));
            chk("R9 out", out_data, {24'h0, exp_val(a, b, sub)} & 32'hFF);
        end

        // R4: overflow held across non-arithmetic instructions
        hold_reset();
        put(12'h000, ins(4'h1, 12'h030)); put(12'h001, ins(4'h3, 12'h031));
        put(12'h002, ins(4'h1, 12'h031)); put(12'h003, ins(4'hA, 0));
        put(12'h004, ins(4'h7, 0));
        put(12'h030, 16'h7FFF); put(12'h031, 16'h0001);
        run(cyc);
        chk("R4 ovf held", ovf, 1); chk("R3 clear after", acc, 0);

        // R5 R7: call, body, return through indirect jump
        hold_reset();
        put(12'h000, ins(4'h0, 12'h040)); put(12'h001, ins(4'h7, 0));
        put(12'h040, 16'hFFFF);
        put(12'h041, ins(4'h1, 12'h050)); put(12'h042, ins(4'hC, 12'h040));
        put(12'h050, 16'h0C0D);
        run(cyc);
        peek(12'h040, w);
        chk("R5 return slot", w, 16'h0001);
        chk("R5 body ran", acc, 16'h0C0D);
        chk("R7 indirect return pc", pc, 2);
        chk("R1 call-body-return cycles", cyc, 6 + 5 + 4 + 4);

        // R6: skip codes against negative, zero, positive
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] v = (k == 0) ? 16'h8001 : (k == 1) ? 16'h0000 : 16'h0042;
                hold_reset();
                put(12'h000, ins(4'h1, 12'h030));
                put(12'h001, {4'h8, 2'(c), 10'h0});
                put(12'h002, ins(4'h9, 12'h005));
                put(12'h003, ins(4'h7, 0));
                put(12'h005, ins(4'h7, 0));
                put(12'h030, v);
                run(cyc);
                chk($sformatf("R6 skip code %0d value %h", c, v), pc,
                    exp_skip(2'(c), v) ? 4 : 6);
            end
        end

        // R8: indirect load, add, store
        hold_reset();
        put(12'h000, ins(4'hD, 12'h060)); put(12'h001, ins(4'hB, 12'h061));
        put(12'h002, ins(4'hE, 12'h062)); put(12'h003, ins(4'h7, 0));
        put(12'h060, 16'hF070); put(12'h061, 16'h0071); put(12'h062, 16'hA072);
        put(12'h070, 16'h7000); put(12'h071, 16'h1000); put(12'h072, 16'h0);
        run(cyc);
        chk("R8 acc", acc, 16'h8000); chk("R8 addi ovf", ovf, 1);
        peek(12'h072, w); chk("R8 indirect store", w, 16'h8000);
        chk("R1 indirect cycles", cyc, 6 * 3 + 4);

        // R7 R9 R11: jump, input keeps high byte, output, no-op
        hold_reset();
        in_data = 8'hA5;
        put(12'h000, ins(4'h9, 12'h010)); put(12'h001, ins(4'h7, 0));
        put(12'h010, ins(4'h1, 12'h030)); put(12'h011, ins(4'h5, 0));
        put(12'h012, ins(4'h6, 0)); put(12'h013, 16'hF123);
        put(12'h014, ins(4'h7, 0)); put(12'h030, 16'h1234);
        run(cyc);
        chk("R9 input merge", acc, 16'h12A5);
        chk("R9 output byte", out_data, 8'hA5);
        chk("R7 jump then R11 no-op pc", pc, 12'h015);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #3000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: bench timeout, got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule